// File: doc/BRIEF.md
# Framed Message Data Register Window

This block sits behind a byte-wide register access port and owns a window of 19 data registers at addresses 07h to 19h. The host exchanges message frames through that window. A frame's first byte gives the total byte count, including the count byte itself. The second byte selects a service, and any parameter bytes follow it. Within one transaction the host first loads the address pointer. It then streams bytes in or out, and the pointer advances after every byte.

A frame must be moved as a whole, starting from the window base. If the pointer is loaded to any other address inside the window, the block rejects the session and ignores its data. Incoming bytes are stored in a capture buffer. When the byte count is reached, the block raises a one-cycle completion strobe, and the buffer holds the frame. Outgoing reads return the response frame that was most recently loaded through a separate load port. Four sticky flags report the following:
- a rejected start
- overflow past the window or past the end of a frame
- an abandoned frame
- a malformed byte count

The write stream never stalls: `wr_ready` is always high. The read stream keeps `rd_valid` and `rd_data` steady until `rd_ready` takes the byte. The response load port holds `rsp_ready` low while a session at the window base is open, so a frame being read is never changed in the middle of the read. The host sends reads or writes in one session, never both in the same cycle.

Top module: `fw_data_window`

## Requirements
- R1: After reset all four flags, `frm_done` and `rd_valid` are 0, and the capture buffer is all zero.
- R2: Loading the pointer with 07h opens the window. `rd_valid` then rises, and reads return the stored response bytes in order, starting with byte 0 (the count byte).
- R3: Loading the pointer with any value from 08h to 19h sets `flag_reject`. Bytes written in that session leave `frm_buf` unchanged and give no `frm_done`, and `rd_valid` stays 0. A pointer value outside 07h..19h neither opens the window nor sets `flag_reject`.
- R4: Byte 0 written after the pointer is loaded with 07h is the byte count. When the number of bytes written equals that count (2..19), `frm_done` is high for exactly one cycle, in the cycle after the handshake of the final byte. At that point, `frm_buf` byte i (bits 8i+7..8i) holds the i-th byte written.
- R5: A byte count below 2 or above 19 sets `flag_malformed`, and that frame produces no `frm_done`.
- R6: A stop after at least one byte of a well-formed frame, but before its count is reached, sets `flag_incomplete` and produces no `frm_done`.
- R7: A byte written after the frame is complete, or after 19 bytes in a session, is discarded and sets `flag_overflow`. `frm_buf` is unchanged.
- R8: Reads do not consume the response. A new session at 07h reads the same frame again from byte 0.
- R9: `rsp_ready` is 0 while a session at the window base is open. A frame offered on the load port in that time is not taken. When `rsp_valid` and `rsp_ready` are both high, the whole response frame (byte i at bits 8i+7..8i) is replaced.
- R10: `bus_start` clears all four flags and closes any open session.
- R11: `wr_ready` is always 1. While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold until the next session event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start condition pulse; clears flags, closes session |
| bus_stop | input | 1 | Stop condition pulse; ends session |
| ptr_we | input | 1 | Address pointer load strobe |
| ptr_val | input | 8 | Address pointer value |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte ready (always 1) |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| rsp_valid | input | 1 | Response frame offered |
| rsp_ready | output | 1 | Response frame may be loaded |
| rsp_frame | input | 152 | Response frame, byte i at bits 8i+7..8i |
| frm_done | output | 1 | One-cycle frame-complete strobe |
| frm_buf | output | 152 | Capture buffer, byte i at bits 8i+7..8i |
| flag_reject | output | 1 | Session started above the window base |
| flag_overflow | output | 1 | Byte discarded past window or frame end |
| flag_incomplete | output | 1 | Frame abandoned by a stop |
| flag_malformed | output | 1 | Byte count out of range |

## Verification
The assertions assume three things about the inputs:
- `bus_start`, `bus_stop` and `ptr_we` are never high in the same cycle.
- The host never asserts `wr_valid` and `rd_ready` together.
- Every session begins with a pointer load after a start.

The hold rule on the read stream is only claimed across cycles with no session event. The bench drives each control input as a separate one-cycle pulse, one cycle after a clock edge. It runs each session in a single direction, and it changes `rd_ready` only between handshakes.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE   = 2'd0,
    WS_OPEN   = 2'd1,
    WS_REJECT = 2'd2
  } win_state_e;
endpackage

// File: rtl/fw_ptr_ctrl.sv
module fw_ptr_ctrl
  import fw_pkg::*;
#(
  parameter int AW   = 8,
  parameter int BASE = 7,
  parameter int NREG = 19,
  parameter int IW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_val,
  input  logic          wr_valid,
  input  logic          rd_ready,
  output win_state_e    state,
  output logic [IW-1:0] idx,
  output logic          win_full,
  output logic          wr_fire,
  output logic          rd_valid,
  output logic          open_pulse,
  output logic          rej_pulse
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] LAST_A = AW'(BASE + NREG - 1);
  localparam logic [IW-1:0] NREG_I = IW'(NREG);

  logic hit_base, hit_hi, wrote_q, rd_fire, sess_evt;

  assign sess_evt   = bus_start || bus_stop;
  assign hit_base   = (ptr_val == BASE_A);
  assign hit_hi     = (ptr_val > BASE_A) && (ptr_val <= LAST_A);
  assign open_pulse = ptr_we && !sess_evt && hit_base;
  assign rej_pulse  = ptr_we && !sess_evt && hit_hi;
  assign win_full   = (idx == NREG_I);
  assign wr_fire    = wr_valid && (state == WS_OPEN);
  assign rd_valid   = (state == WS_OPEN) && !wrote_q && !win_full;
  assign rd_fire    = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WS_IDLE;
      idx     <= '0;
      wrote_q <= 1'b0;
    end else if (sess_evt) begin
      state   <= WS_IDLE;
      idx     <= '0;
      wrote_q <= 1'b0;
    end else if (ptr_we) begin
      idx     <= '0;
      wrote_q <= 1'b0;
      if (hit_base)    state <= WS_OPEN;
      else if (hit_hi) state <= WS_REJECT;
      else             state <= WS_IDLE;
    end else if (wr_fire) begin
      wrote_q <= 1'b1;
      if (!win_full) idx <= idx + 1'b1;
    end else if (rd_fire) begin
      idx <= idx + 1'b1;
    end
  end

  // R7: the byte index never runs past the window end
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= NREG_I);

  // R11: an offered read byte stays offered when nothing disturbs the session
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !bus_start && !bus_stop && !ptr_we && !wr_valid)
      |=> rd_valid);
endmodule

// File: rtl/fw_wr_capture.sv
module fw_wr_capture #(
  parameter int NREG = 19,
  parameter int DW   = 8,
  parameter int IW   = 5,
  parameter int MINC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stop,
  input  logic             open_pulse,
  input  logic             rej_pulse,
  input  logic             wr_fire,
  input  logic             win_full,
  input  logic [IW-1:0]    idx,
  input  logic [DW-1:0]    wr_data,
  output logic [NREG*DW-1:0] buf_flat,
  output logic             frm_done,
  output logic             flag_ovf,
  output logic             flag_inc,
  output logic             flag_mal,
  output logic             flag_rej
);
  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] cnt_q;
  logic          mal_q, cmp_q, any_q, done_q;
  logic          bad_cnt, last_byte, drop;

  assign bad_cnt   = (wr_data < DW'(MINC)) || (wr_data > DW'(NREG));
  assign last_byte = (DW'(idx) + DW'(1)) == cnt_q;
  assign drop      = win_full || cmp_q;
  assign frm_done  = done_q;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign buf_flat[g*DW +: DW] = mem[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      cnt_q    <= '0;
      mal_q    <= 1'b0;
      cmp_q    <= 1'b0;
      any_q    <= 1'b0;
      done_q   <= 1'b0;
      flag_ovf <= 1'b0;
      flag_inc <= 1'b0;
      flag_mal <= 1'b0;
      flag_rej <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr) begin
        flag_ovf <= 1'b0;
        flag_inc <= 1'b0;
        flag_mal <= 1'b0;
        flag_rej <= 1'b0;
        mal_q    <= 1'b0;
        cmp_q    <= 1'b0;
        any_q    <= 1'b0;
      end else begin
        if (rej_pulse) flag_rej <= 1'b1;
        if (open_pulse) begin
          mal_q <= 1'b0;
          cmp_q <= 1'b0;
          any_q <= 1'b0;
        end else if (stop) begin
          if (any_q && !cmp_q && !mal_q) flag_inc <= 1'b1;
          mal_q <= 1'b0;
          cmp_q <= 1'b0;
          any_q <= 1'b0;
        end else if (wr_fire) begin
          if (drop) begin
            flag_ovf <= 1'b1;
          end else begin
            mem[idx[IW-1:0]] <= wr_data;
            any_q <= 1'b1;
            if (idx == '0) begin
              cnt_q <= wr_data;
              if (bad_cnt) begin
                mal_q    <= 1'b1;
                flag_mal <= 1'b1;
              end
            end else if (!mal_q && last_byte) begin
              done_q <= 1'b1;
              cmp_q  <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R4: completion is a single-cycle strobe
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);

  // R5: a frame flagged malformed never completes
  p_mal_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mal_q |=> !frm_done);

  // R7: a discarded byte leaves the capture buffer untouched
  p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && drop && !clr && !open_pulse && !stop) |=> $stable(buf_flat));

  // R10: a start condition leaves every flag cleared
  p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!flag_ovf && !flag_inc && !flag_mal && !flag_rej));
endmodule

// File: rtl/fw_rsp_store.sv
module fw_rsp_store #(
  parameter int NREG = 19,
  parameter int DW   = 8,
  parameter int IW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [NREG*DW-1:0] frame_flat,
  input  logic [IW-1:0]      idx,
  output logic [DW-1:0]      rd_data
);
  localparam logic [IW-1:0] NREG_I = IW'(NREG);

  logic [DW-1:0] mem [NREG];
  logic [IW-1:0] idx_s;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[g] <= '0;
      else if (load_en) mem[g] <= frame_flat[g*DW +: DW];
    end
  end

  assign idx_s   = (idx < NREG_I) ? idx : '0;
  assign rd_data = (idx < NREG_I) ? mem[idx_s] : '0;
endmodule

// File: rtl/fw_data_window.sv
module fw_data_window
  import fw_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int BASE = 7,
  parameter int NREG = 19,
  parameter int MINC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               ptr_we,
  input  logic [AW-1:0]      ptr_val,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [DW-1:0]      wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [DW-1:0]      rd_data,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [NREG*DW-1:0] rsp_frame,
  output logic               frm_done,
  output logic [NREG*DW-1:0] frm_buf,
  output logic               flag_reject,
  output logic               flag_overflow,
  output logic               flag_incomplete,
  output logic               flag_malformed
);
  localparam int IW = $clog2(NREG + 1);

  win_state_e    state;
  logic [IW-1:0] idx;
  logic          win_full, wr_fire, open_pulse, rej_pulse;

  assign wr_ready  = 1'b1;
  assign rsp_ready = (state != WS_OPEN);

  fw_ptr_ctrl #(.AW(AW), .BASE(BASE), .NREG(NREG), .IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .ptr_we(ptr_we), .ptr_val(ptr_val), .wr_valid(wr_valid),
    .rd_ready(rd_ready), .state(state), .idx(idx), .win_full(win_full),
    .wr_fire(wr_fire), .rd_valid(rd_valid), .open_pulse(open_pulse),
    .rej_pulse(rej_pulse)
  );

  fw_wr_capture #(.NREG(NREG), .DW(DW), .IW(IW), .MINC(MINC)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(bus_start), .stop(bus_stop),
    .open_pulse(open_pulse), .rej_pulse(rej_pulse), .wr_fire(wr_fire),
    .win_full(win_full), .idx(idx), .wr_data(wr_data), .buf_flat(frm_buf),
    .frm_done(frm_done), .flag_ovf(flag_overflow), .flag_inc(flag_incomplete),
    .flag_mal(flag_malformed), .flag_rej(flag_reject)
  );

  fw_rsp_store #(.NREG(NREG), .DW(DW), .IW(IW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load_en(rsp_valid && rsp_ready),
    .frame_flat(rsp_frame), .idx(idx), .rd_data(rd_data)
  );

  // R9: the response store is locked while a base session is open
  p_rsp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rsp_ready);

  // R3: a session in the rejected state always carries the reject flag
  p_reject_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_REJECT) |-> (flag_reject && !rd_valid));

  // R11: the offered read byte value holds while waiting for the host
  p_rd_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !bus_start && !bus_stop && !ptr_we && !wr_valid)
      |=> $stable(rd_data));
endmodule

// File: tb/fw_data_window_tb.sv
module fw_data_window_tb;
  localparam int NREG = 19;
  localparam int FW   = NREG * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_start = 0, bus_stop = 0, ptr_we = 0, wr_valid = 0, rd_ready = 0, rsp_valid = 0;
  logic [7:0] ptr_val = '0, wr_data = '0;
  logic [FW-1:0] rsp_frame = '0;
  logic wr_ready, rd_valid, rsp_ready, frm_done;
  logic [7:0] rd_data;
  logic [FW-1:0] frm_buf;
  logic flag_reject, flag_overflow, flag_incomplete, flag_malformed;

  always #2 clk = ~clk;

  fw_data_window u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .ptr_we(ptr_we), .ptr_val(ptr_val), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame),
    .frm_done(frm_done), .frm_buf(frm_buf), .flag_reject(flag_reject),
    .flag_overflow(flag_overflow), .flag_incomplete(flag_incomplete),
    .flag_malformed(flag_malformed)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [7:0]    exp_rd_q[$];
  logic [FW-1:0] exp_frm_q[$];
  logic [FW-1:0] buf_m = '0, rsp_m = '0, frm_b = '0;
  logic [7:0]    wb [32];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares design output against the scoreboard queues
  always @(negedge clk) if (rst_n) begin
    if (rd_valid && rd_ready) begin
      if (exp_rd_q.size() == 0) chk(0, "R2 unexpected read byte", {24'd0, rd_data}, 0);
      else begin
        automatic logic [7:0] e = exp_rd_q.pop_front();
        chk(rd_data == e, "R2 read byte order", {24'd0, rd_data}, {24'd0, e});
      end
    end
    if (frm_done) begin
      if (exp_frm_q.size() == 0) chk(0, "R5 unexpected frm_done", 1, 0);
      else begin
        automatic logic [FW-1:0] ef = exp_frm_q.pop_front();
        chk(frm_buf == ef, "R4 completed frame contents", frm_buf[31:0], ef[31:0]);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic do_start(); cyc(1); bus_start = 1; cyc(1); bus_start = 0; endtask
  task automatic do_stop();  cyc(1); bus_stop  = 1; cyc(1); bus_stop  = 0; endtask
  task automatic load_ptr(input logic [7:0] a); cyc(1); ptr_we = 1; ptr_val = a; cyc(1); ptr_we = 0; endtask

  task automatic load_rsp(input logic [FW-1:0] f);
    cyc(1); rsp_frame = f; rsp_valid = 1; cyc(1); rsp_valid = 0;
  endtask

  // driver: writes wb[0..n-1], updates the buffer model and queues the expected frame
  task automatic wr_seq(input int n, input bit open);
    int cnt = int'(wb[0]);
    bit done = 0;
    for (int i = 0; i < n; i++) begin
      if (open && i < NREG && !done) begin
        buf_m[i*8 +: 8] = wb[i];
        if (i > 0 && cnt >= 2 && cnt <= NREG && i + 1 == cnt) begin
          done = 1;
          exp_frm_q.push_back(buf_m);
        end
      end
    end
    cyc(1);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = wb[i];
      cyc(1);
    end
    wr_valid = 0;
    cyc(2);
  endtask

  task automatic rd_seq(input int n);
    int got = 0;
    int k = 0;
    for (int i = 0; i < n; i++) exp_rd_q.push_back(rsp_m[i*8 +: 8]);
    cyc(1);
    while (got < n) begin
      rd_ready = (k % 3 != 1);
      k++;
      @(negedge clk);
      if (rd_valid && rd_ready) got++;
      @(posedge clk); #1;
    end
    rd_ready = 0;
    cyc(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa, fb;
    cyc(4); rst_n = 1; cyc(1);
    @(negedge clk);
    // R1 reset state
    chk({flag_reject, flag_overflow, flag_incomplete, flag_malformed} == 0, "R1 flags after reset",
        {flag_reject, flag_overflow, flag_incomplete, flag_malformed}, 0);
    chk(!frm_done && !rd_valid, "R1 done/rd_valid after reset", {frm_done, rd_valid}, 0);
    chk(frm_buf == '0, "R1 buffer after reset", frm_buf[31:0], 0);
    chk(wr_ready == 1, "R11 wr_ready always high", wr_ready, 1);

    fa = '0;
    for (int i = 0; i < NREG; i++) fa[i*8 +: 8] = 8'hA0 + 8'(i);
    fa[7:0] = 8'd5;
    fb = '0;
    for (int i = 0; i < NREG; i++) fb[i*8 +: 8] = 8'h30 + 8'(i);
    fb[7:0] = 8'd3;

    // R9 load while idle
    chk(rsp_ready == 1, "R9 rsp_ready while idle", rsp_ready, 1);
    load_rsp(fa); rsp_m = fa;

    // R2 read from base with back-pressure
    do_start(); load_ptr(8'h07);
    @(negedge clk);
    chk(rd_valid == 1, "R2 rd_valid after base load", rd_valid, 1);
    chk(rsp_ready == 0, "R9 rsp_ready low while open", rsp_ready, 0);
    rd_seq(5);
    do_stop();
    chk(exp_rd_q.size() == 0, "R2 all read bytes seen", exp_rd_q.size(), 0);

    // R8 reread returns the same frame
    do_start(); load_ptr(8'h07); rd_seq(3); do_stop();
    chk(exp_rd_q.size() == 0, "R8 reread bytes seen", exp_rd_q.size(), 0);

    // R9 offer while open is refused
    do_start(); load_ptr(8'h07); load_rsp(fb); do_stop();
    do_start(); load_ptr(8'h07); rd_seq(2); do_stop();
    chk(exp_rd_q.size() == 0, "R9 old frame kept", exp_rd_q.size(), 0);
    load_rsp(fb); rsp_m = fb;
    do_start(); load_ptr(8'h07); rd_seq(3); do_stop();
    chk(exp_rd_q.size() == 0, "R9 new frame loaded", exp_rd_q.size(), 0);

    // R4 short frame
    do_start(); load_ptr(8'h07);
    wb[0] = 8'd4; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
    wr_seq(4, 1); do_stop();
    @(negedge clk);
    chk(exp_frm_q.size() == 0, "R4 short frame completed", exp_frm_q.size(), 0);
    chk(flag_incomplete == 0, "R6 no incomplete on done frame", flag_incomplete, 0);

    // R4 full-window frame
    do_start(); load_ptr(8'h07);
    wb[0] = 8'd19;
    for (int i = 1; i < NREG; i++) wb[i] = 8'(i * 3);
    wr_seq(19, 1); do_stop();
    @(negedge clk);
    chk(exp_frm_q.size() == 0, "R4 19-byte frame completed", exp_frm_q.size(), 0);
    chk(flag_overflow == 0, "R7 no overflow on exact fill", flag_overflow, 0);

    // R5 count too small
    do_start(); load_ptr(8'h07);
    wb[0] = 8'd1; wb[1] = 8'h55;
    wr_seq(2, 1); do_stop();
    @(negedge clk);
    chk(flag_malformed == 1, "R5 count 1 malformed", flag_malformed, 1);
    chk(flag_incomplete == 0, "R5 malformed not incomplete", flag_incomplete, 0);

    // R5 count too large
    do_start(); load_ptr(8'h07);
    wb[0] = 8'd20; wb[1] = 8'h01; wb[2] = 8'h02;
    wr_seq(3, 1); do_stop();
    @(negedge clk);
    chk(flag_malformed == 1, "R5 count 20 malformed", flag_malformed, 1);
    chk(frm_buf == buf_m, "R5 buffer holds written bytes", frm_buf[31:0], buf_m[31:0]);

    // R6 abandoned frame
    do_start(); load_ptr(8'h07);
    wb[0] = 8'd5; wb[1] = 8'h01; wb[2] = 8'h02;
    wr_seq(3, 1);
    @(negedge clk);
    chk(flag_incomplete == 0, "R6 no flag before stop", flag_incomplete, 0);
    do_stop();
    @(negedge clk);
    chk(flag_incomplete == 1, "R6 incomplete after stop", flag_incomplete, 1);

    // R7 byte after completion
    do_start(); load_ptr(8'h07);
    wb[0] = 8'd3; wb[1] = 8'h07; wb[2] = 8'h08; wb[3] = 8'hEE;
    wr_seq(4, 1);
    @(negedge clk);
    chk(flag_overflow == 1, "R7 overflow after completion", flag_overflow, 1);
    chk(frm_buf == buf_m, "R7 buffer unchanged by extra byte", frm_buf[31:0], buf_m[31:0]);
    do_stop();

    // R7 window full on malformed frame
    do_start(); load_ptr(8'h07);
    wb[0] = 8'd25;
    for (int i = 1; i < 21; i++) wb[i] = 8'h80 + 8'(i);
    wr_seq(21, 1);
    @(negedge clk);
    chk(flag_overflow == 1, "R7 overflow past window end", flag_overflow, 1);
    chk(frm_buf == buf_m, "R7 buffer after window full", frm_buf[159:128], buf_m[159:128]);
    do_stop();

    // R3 rejected starts
    do_start(); load_ptr(8'h0A);
    @(negedge clk);
    chk(flag_reject == 1, "R3 start at 0Ah rejected", flag_reject, 1);
    chk(rd_valid == 0, "R3 no read when rejected", rd_valid, 0);
    wb[0] = 8'd2; wb[1] = 8'h77;
    wr_seq(2, 0);
    @(negedge clk);
    chk(frm_buf == buf_m, "R3 rejected writes ignored", frm_buf[31:0], buf_m[31:0]);
    chk(exp_frm_q.size() == 0, "R3 no completion when rejected", exp_frm_q.size(), 0);
    do_stop();
    do_start(); load_ptr(8'h19);
    @(negedge clk);
    chk(flag_reject == 1, "R3 start at 19h rejected", flag_reject, 1);
    do_stop();
    do_start(); load_ptr(8'h1A);
    @(negedge clk);
    chk(flag_reject == 0 && rd_valid == 0, "R3 outside window ignored", {flag_reject, rd_valid}, 0);
    do_stop();

    // R10 start clears flags and closes session
    do_start(); load_ptr(8'h0B); do_stop();
    do_start(); load_ptr(8'h07);
    @(negedge clk);
    chk(rd_valid == 1, "R10 session open before start", rd_valid, 1);
    do_start();
    @(negedge clk);
    chk({flag_reject, flag_overflow, flag_incomplete, flag_malformed} == 0, "R10 flags cleared",
        {flag_reject, flag_overflow, flag_incomplete, flag_malformed}, 0);
    chk(rd_valid == 0 && rsp_ready == 1, "R10 session closed", {rd_valid, rsp_ready}, 2'b01);

    cyc(3);
    chk(exp_frm_q.size() == 0 && exp_rd_q.size() == 0, "R4 scoreboard drained",
        exp_frm_q.size() + exp_rd_q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule